// File: doc/BRIEF.md
# Mode-Dependent Stack Pointer Unit

This block holds a processor's stack pointer and performs the pointer arithmetic for stack accesses. A push strobe moves the pointer down by the operand size before the access. A pop strobe uses the current pointer for the access and then moves the pointer up by the operand size. With each access the block returns the address the memory access should use.

A mode input selects how far the arithmetic reaches. In native mode only the low 16 bits take part and wrap modulo 2^16, and the upper 16 bits are left as they were. In extended mode the carry or borrow runs through all 32 bits. A load port writes the pointer directly. With the long-word qualifier the load writes all 32 bits. Without it the load writes only the low 16 bits.

All outputs are registered, so the result of a strobe sampled at one rising edge is visible right after that edge.

Top module: `stack_ptr_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `sp_out`, `acc_addr` and `acc_valid` to zero.
- R2: In native mode (`ext_mode`=0), a push or pop changes `sp_out[15:0]` modulo 2^16 and leaves `sp_out[31:16]` unchanged. For example, 0x0001FFFE popped by a word gives 0x00010000.
- R3: In extended mode (`ext_mode`=1), a push or pop changes `sp_out` modulo 2^32. For example, 0x0001FFFE popped by a word gives 0x00020000.
- R4: A push pre-decrements the pointer. After the edge, `acc_addr` equals the new `sp_out` and `acc_valid` is 1.
- R5: A pop post-increments the pointer. After the edge, `acc_addr` equals the pointer value from before the pop and `acc_valid` is 1.
- R6: The `op_size` encodings set the step size: 0 (byte) steps by 1, 1 (word) steps by 2, and 2 (long word) steps by 4. The unused code 3 also steps by 4.
- R7: A load with `load_long`=0 writes `load_data[15:0]` into `sp_out[15:0]` and keeps `sp_out[31:16]`.
- R8: A load with `load_long`=1 writes all 32 bits of `load_data` into `sp_out`.
- R9: Priority is load, then push, then pop. A load produces no access (`acc_valid`=0, `acc_addr` held). When push and pop are both asserted, only the push takes effect.
- R10: In a cycle with no load, push or pop, `sp_out` and `acc_addr` hold their values and `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0 = 16-bit wrap, 1 = 32-bit arithmetic |
| push | input | 1 | Push strobe (pre-decrement) |
| pop | input | 1 | Pop strobe (post-increment) |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long word |
| load | input | 1 | Direct pointer write strobe |
| load_long | input | 1 | Load writes all 32 bits when 1, low 16 bits when 0 |
| load_data | input | 32 | Value for the load |
| sp_out | output | 32 | Current stack pointer |
| acc_addr | output | 32 | Address of the most recent stack access |
| acc_valid | output | 1 | High for one cycle after a push or pop |

## Verification
A corrupted pointer shows up on `sp_out` immediately after the edge where it goes wrong. Because every later push or pop computes from that pointer, the error also reaches `acc_addr` on the next access. A wrong mode path leaks a carry into, or drops a borrow from, bits 31:16. This is visible only when the low half crosses 0x0000/0xFFFF, so the vectors drive the pointer across that boundary in both directions and in both modes.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } sp_size_e;
endpackage

// File: rtl/sp_step_decode.sv
module sp_step_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        size_code,
  output logic [ADDR_W-1:0] step
);
  import sp_pkg::*;

  always_comb begin
    case (sp_size_e'(size_code))
      SZ_BYTE: step = ADDR_W'(1);
      SZ_WORD: step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end
endmodule

// File: rtl/sp_mode_adder.sv
module sp_mode_adder #(
  parameter int ADDR_W   = 32,
  parameter int NATIVE_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  input  logic              subtract,
  input  logic              ext_mode,
  output logic [ADDR_W-1:0] result
);
  localparam int HI_W = ADDR_W - NATIVE_W;

  logic [ADDR_W-1:0]   full_res;
  logic [NATIVE_W-1:0] low_res;

  always_comb begin
    if (subtract) begin
      full_res = base - step;
      low_res  = base[NATIVE_W-1:0] - step[NATIVE_W-1:0];
    end else begin
      full_res = base + step;
      low_res  = base[NATIVE_W-1:0] + step[NATIVE_W-1:0];
    end
  end

  generate
    if (HI_W > 0) begin : g_split
      assign result = ext_mode ? full_res : {base[ADDR_W-1:NATIVE_W], low_res};
    end else begin : g_flat
      assign result = full_res;
    end
  endgenerate
endmodule

// File: rtl/sp_load_merge.sv
module sp_load_merge #(
  parameter int ADDR_W   = 32,
  parameter int NATIVE_W = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] data,
  input  logic              long_wr,
  output logic [ADDR_W-1:0] merged
);
  generate
    if (ADDR_W > NATIVE_W) begin : g_split
      assign merged = long_wr ? data : {cur[ADDR_W-1:NATIVE_W], data[NATIVE_W-1:0]};
    end else begin : g_flat
      assign merged = data;
    end
  endgenerate
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int ADDR_W   = 32,
  parameter int NATIVE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              push,
  input  logic              pop,
  input  logic [1:0]        op_size,
  input  logic              load,
  input  logic              load_long,
  input  logic [ADDR_W-1:0] load_data,
  output logic [ADDR_W-1:0] sp_out,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_valid
);
  logic [ADDR_W-1:0] sp_q, addr_q;
  logic              valid_q;
  logic [ADDR_W-1:0] step, adj, merged;

  sp_step_decode #(.ADDR_W(ADDR_W)) i_step (
    .size_code(op_size),
    .step     (step)
  );

  sp_mode_adder #(.ADDR_W(ADDR_W), .NATIVE_W(NATIVE_W)) i_add (
    .base    (sp_q),
    .step    (step),
    .subtract(push),
    .ext_mode(ext_mode),
    .result  (adj)
  );

  sp_load_merge #(.ADDR_W(ADDR_W), .NATIVE_W(NATIVE_W)) i_merge (
    .cur    (sp_q),
    .data   (load_data),
    .long_wr(load_long),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      sp_q    <= merged;
      valid_q <= 1'b0;
    end else if (push) begin
      sp_q    <= adj;
      addr_q  <= adj;
      valid_q <= 1'b1;
    end else if (pop) begin
      addr_q  <= sp_q;
      sp_q    <= adj;
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign sp_out    = sp_q;
  assign acc_addr  = addr_q;
  assign acc_valid = valid_q;
endmodule

// File: rtl/sp_unit_checker.sv
module sp_unit_checker #(
  parameter int ADDR_W   = 32,
  parameter int NATIVE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_mode,
  input logic              push,
  input logic              pop,
  input logic              load,
  input logic              load_long,
  input logic [ADDR_W-1:0] load_data,
  input logic [ADDR_W-1:0] sp_out,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_valid
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (sp_out == '0 && acc_addr == '0 && !acc_valid)); // R1
  AST_NATIVE_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode && !load && (push || pop)) |=> sp_out[ADDR_W-1:NATIVE_W] == $past(sp_out[ADDR_W-1:NATIVE_W])); // R2
  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (rst)
    (push && !load) |=> (acc_valid && acc_addr == sp_out)); // R4
  AST_POP_ADDR: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !load) |=> (acc_valid && acc_addr == $past(sp_out))); // R5
  AST_SHORT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !load_long) |=> (sp_out[ADDR_W-1:NATIVE_W] == $past(sp_out[ADDR_W-1:NATIVE_W])
                              && sp_out[NATIVE_W-1:0] == $past(load_data[NATIVE_W-1:0]))); // R7
  AST_LONG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && load_long) |=> sp_out == $past(load_data)); // R8
  AST_LOAD_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    load |=> (!acc_valid && $stable(acc_addr))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !push && !pop) |=> ($stable(sp_out) && $stable(acc_addr) && !acc_valid)); // R10
endmodule

bind stack_ptr_unit sp_unit_checker #(.ADDR_W(ADDR_W), .NATIVE_W(NATIVE_W)) i_chk (
  .clk(clk), .rst(rst), .ext_mode(ext_mode), .push(push), .pop(pop),
  .load(load), .load_long(load_long), .load_data(load_data),
  .sp_out(sp_out), .acc_addr(acc_addr), .acc_valid(acc_valid)
);

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic        ext;
    logic        psh;
    logic        pp;
    logic [1:0]  sz;
    logic        ld;
    logic        lng;
    logic [31:0] data;
    logic [31:0] e_sp;
    logic [31:0] e_addr;
    logic        e_val;
  } vec_t;

  localparam logic [103:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,32'h0001FFFE, 32'h0001FFFE,32'h00000000,1'b0},
    {1'b0,1'b0,1'b1,2'd1,1'b0,1'b0,32'h0,        32'h00010000,32'h0001FFFE,1'b1},
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,32'h0001FFFE, 32'h0001FFFE,32'h0001FFFE,1'b0},
    {1'b1,1'b0,1'b1,2'd1,1'b0,1'b0,32'h0,        32'h00020000,32'h0001FFFE,1'b1},
    {1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,32'h0,        32'h0002FFFF,32'h0002FFFF,1'b1},
    {1'b1,1'b1,1'b0,2'd2,1'b0,1'b0,32'h0,        32'h0002FFFB,32'h0002FFFB,1'b1},
    {1'b1,1'b0,1'b1,2'd3,1'b0,1'b0,32'h0,        32'h0002FFFF,32'h0002FFFB,1'b1},
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0,        32'h0002FFFF,32'h0002FFFB,1'b0},
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,32'hABCD1234, 32'h00021234,32'h0002FFFB,1'b0},
    {1'b1,1'b1,1'b1,2'd1,1'b1,1'b1,32'h12345678, 32'h12345678,32'h0002FFFB,1'b0},
    {1'b0,1'b1,1'b1,2'd1,1'b0,1'b0,32'h0,        32'h12345676,32'h12345676,1'b1},
    {1'b1,1'b0,1'b0,2'd0,1'b1,1'b1,32'hFFFFFFFE, 32'hFFFFFFFE,32'h12345676,1'b0},
    {1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,32'h0,        32'h00000002,32'hFFFFFFFE,1'b1},
    {1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,32'h0,        32'h00000000,32'h00000000,1'b1},
    {1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,32'h0,        32'h0000FFFE,32'h0000FFFE,1'b1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R8 long load";
      1: return "R2 R5 native pop wrap";
      2: return "R8 reload";
      3: return "R3 R5 extended pop carry";
      4: return "R2 R4 R6 native byte push borrow";
      5: return "R3 R4 R6 extended long push";
      6: return "R3 R6 size code 3";
      7: return "R10 idle hold";
      8: return "R7 short load";
      9: return "R9 load beats push and pop";
      10: return "R9 push beats pop";
      11: return "R8 load near top";
      12: return "R3 extended wrap 2^32";
      13: return "R4 native push to zero";
      default: return "R2 native push borrow";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b0, push = 1'b0, pop = 1'b0, load = 1'b0, load_long = 1'b0;
  logic [1:0]  op_size = 2'd0;
  logic [31:0] load_data = '0;
  logic [31:0] sp_out, acc_addr;
  logic        acc_valid;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .push(push), .pop(pop),
    .op_size(op_size), .load(load), .load_long(load_long), .load_data(load_data),
    .sp_out(sp_out), .acc_addr(acc_addr), .acc_valid(acc_valid)
  );

  task automatic check(input string tag, input logic [31:0] esp,
                       input logic [31:0] eaddr, input logic evalid);
    checks++;
    if (sp_out !== esp || acc_addr !== eaddr || acc_valid !== evalid) begin
      fails++;
      $display("FAIL %s: sp=%h addr=%h valid=%b expected sp=%h addr=%h valid=%b",
               tag, sp_out, acc_addr, acc_valid, esp, eaddr, evalid);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 32'h0, 32'h0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      ext_mode = v.ext; push = v.psh; pop = v.pp; op_size = v.sz;
      load = v.ld; load_long = v.lng; load_data = v.data;
      @(negedge clk);
      check(tag_of(i), v.e_sp, v.e_addr, v.e_val);
    end
    // R1: reset in mid-run, with a push pending, clears everything
    push = 1'b1; pop = 1'b0; load = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 reset overrides push", 32'h0, 32'h0, 1'b0);
    // R2: native pop from 0xFFFF word stays in the low half
    rst = 1'b0; push = 1'b0; load = 1'b1; load_long = 1'b1; load_data = 32'h7777FFFF;
    @(negedge clk);
    load = 1'b0; pop = 1'b1; ext_mode = 1'b0; op_size = 2'd2;
    @(negedge clk);
    check("R2 native long pop wrap", 32'h77770003, 32'h7777FFFF, 1'b1);
    pop = 1'b0;
    @(negedge clk);
    check("R10 idle after pop", 32'h77770003, 32'h7777FFFF, 1'b0);
    finish_run();
  end
endmodule